// File: doc/BRIEF.md
# Program Flow Sequencer with Return Stack

This block sequences the fetch address of a small microcontroller whose instructions are 16 bits wide. Each time the core finishes an instruction it raises `instr_done` together with a decoded flow command, a condition selector, a target address and the carry and zero results from the ALU. The sequencer then works out the next fetch address. It keeps the carry, zero and interrupt-enable flags. It also holds a four-entry return stack that calls and interrupts share.

An interrupt can be taken only at an instruction boundary. The request is taken when `irq_req` is high and the interrupt-enable flag, as left by the instruction that just completed, is set. The controller has two states. `ST_RUN` accepts one command per `instr_done` cycle. The transition `RUN→ENTER` fires when an interrupt is accepted at a boundary. `ST_ENTER` lasts exactly one cycle, with `busy_o` high. In that cycle the controller pushes the return address and both flags, loads the vector, clears interrupt-enable and takes the transition `ENTER→RUN`. Every other event (reset, or `instr_done` without an accepted interrupt) keeps or returns the controller in `ST_RUN`.

Command encoding on `cmd`:

| Code | Command |
|------|---------|
| 0 | NEXT |
| 1 | ALU |
| 2 | JUMP |
| 3 | BRANCH |
| 4 | CALL |
| 5 | RET |
| 6 | RETI |
| 7 | INTCTL |

Top module: `pfc_top`

## Requirements
- R1: After reset the outputs are as follows: `pc_o`=0, `carry_o`=0, `zero_o`=0, `ie_o`=0, `stk_err_o`=0 and `busy_o`=0. The return stack is empty.
- R2: A NEXT (0) or ALU (1) command sets the PC to PC+1. The PC is 10 bits wide and wraps from 0x3FF to 0x000.
- R3: An ALU command loads `carry_o` and `zero_o` from `alu_carry` and `alu_zero`. No command other than ALU and RETI changes these flags.
- R4: A JUMP (2) command loads the PC from `target`.
- R5: A BRANCH (3) command loads `target` when its condition is true and otherwise steps to PC+1. The `cond_sel` codes are: 00 = zero set, 01 = zero clear, 10 = carry set, 11 = carry clear.
- R6: A CALL (4) command pushes PC+1 and loads `target`. A RET (5) command loads the most recently pushed address.
- R7: The stack holds four entries and returns them in last-in, first-out order. A push onto a full stack overwrites the oldest entry.
- R8: A pop from an empty stack returns address 0. `stk_err_o` is set by an overflow or an underflow and stays set until reset.
- R9: An interrupt is accepted when `instr_done` is high, `irq_req` is high and the post-instruction interrupt-enable flag is 1. `busy_o` is then high for one cycle, while `pc_o` shows the address that follows the completed instruction. After that cycle `pc_o` equals `VEC_ADDR` (default 0x008) and `ie_o`=0.
- R10: A RETI (6) command pops the stack and restores the PC, carry and zero from the popped entry. It also sets `ie_o` to 1.
- R11: An INTCTL (7) command writes `cond_sel[0]` to `ie_o` and steps the PC.
- R12: While `instr_done` is low, or while `busy_o` is high, the command inputs are ignored. The PC and flags keep their values, and no interrupt is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_done | input | 1 | Instruction boundary: command inputs are valid |
| cmd | input | 3 | Flow command code |
| cond_sel | input | 2 | Branch condition select; bit 0 is the enable value for INTCTL |
| target | input | 10 | Jump, branch or call destination |
| alu_carry | input | 1 | Carry result of the ALU instruction |
| alu_zero | input | 1 | Zero result of the ALU instruction |
| irq_req | input | 1 | Pending interrupt request |
| pc_o | output | 10 | Next fetch address |
| busy_o | output | 1 | Interrupt entry cycle in progress; commands are ignored |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| ie_o | output | 1 | Interrupt-enable flag |
| stk_err_o | output | 1 | Sticky stack overflow or underflow status |

## Verification
Damage to the stack pointer or to the entry count does not show when the damage occurs. It becomes visible only at the next RET or RETI, when `pc_o` takes a wrong address one cycle after that command. An underflow can also show up as a wrong `stk_err_o`. A corrupted carry or zero flag first appears on the `carry_o`/`zero_o` ports. It then shows up at the next conditional branch, one cycle later, as a PC that went to the wrong side. A controller stuck in `ST_ENTER` keeps `busy_o` high for longer than the single cycle that is allowed, so the fault shows on the very next edge.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [2:0] {
        CMD_NEXT   = 3'd0,
        CMD_ALU    = 3'd1,
        CMD_JUMP   = 3'd2,
        CMD_BRANCH = 3'd3,
        CMD_CALL   = 3'd4,
        CMD_RET    = 3'd5,
        CMD_RETI   = 3'd6,
        CMD_INTCTL = 3'd7
    } pfc_cmd_e;

    typedef enum logic [1:0] {
        COND_Z  = 2'b00,
        COND_NZ = 2'b01,
        COND_C  = 2'b10,
        COND_NC = 2'b11
    } pfc_cond_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTER = 1'b1
    } pfc_state_e;

endpackage

// File: rtl/pfc_cond.sv
module pfc_cond
    import pfc_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       carry,
    input  logic       zero,
    output logic       take
);

    always_comb begin
        unique case (pfc_cond_e'(cond_sel))
            COND_Z:  take = zero;
            COND_NZ: take = !zero;
            COND_C:  take = carry;
            COND_NC: take = !carry;
        endcase
    end

endmodule

// File: rtl/pfc_stack.sv
module pfc_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] rd_idx;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  slots [DEPTH];

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign rd_idx = (wr_ptr_q == '0) ? PW'(DEPTH - 1) : wr_ptr_q - 1'b1;
    assign top    = empty ? '0 : slots[rd_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (push && wr_ptr_q == PW'(g)) begin
                slot_q <= din;
            end
        end
        assign slots[g] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (push) begin
            wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (!full) cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            wr_ptr_q <= rd_idx;
            cnt_q    <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pfc_top.sv
module pfc_top
    import pfc_pkg::*;
#(
    parameter int PC_W      = 10,
    parameter int STK_DEPTH = 4,
    parameter int VEC_ADDR  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_done,
    input  logic [2:0]      cmd,
    input  logic [1:0]      cond_sel,
    input  logic [PC_W-1:0] target,
    input  logic            alu_carry,
    input  logic            alu_zero,
    input  logic            irq_req,
    output logic [PC_W-1:0] pc_o,
    output logic            busy_o,
    output logic            carry_o,
    output logic            zero_o,
    output logic            ie_o,
    output logic            stk_err_o
);

    localparam int EW = PC_W + 2;

    pfc_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d, pc_inc;
    logic            c_q, c_d, z_q, z_d, ie_q, ie_d, err_q, err_d;
    logic            push, pop, stk_empty, stk_full, take;
    logic [EW-1:0]   push_data, stk_top;

    pfc_cond u_cond (
        .cond_sel (cond_sel),
        .carry    (c_q),
        .zero     (z_q),
        .take     (take)
    );

    pfc_stack #(.W(EW), .DEPTH(STK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_data),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    assign pc_inc = pc_q + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
            ie_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            pc_q  <= pc_d;
            c_q   <= c_d;
            z_q   <= z_d;
            ie_q  <= ie_d;
            err_q <= err_d;
        end
    end

    // Next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        c_d       = c_q;
        z_d       = z_q;
        ie_d      = ie_q;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = {c_q, z_q, pc_q};
        unique case (state_q)
            ST_RUN: begin
                if (instr_done) begin
                    unique case (pfc_cmd_e'(cmd))
                        CMD_NEXT: pc_d = pc_inc;
                        CMD_ALU: begin
                            pc_d = pc_inc;
                            c_d  = alu_carry;
                            z_d  = alu_zero;
                        end
                        CMD_JUMP:   pc_d = target;
                        CMD_BRANCH: pc_d = take ? target : pc_inc;
                        CMD_CALL: begin
                            push      = 1'b1;
                            push_data = {c_q, z_q, pc_inc};
                            pc_d      = target;
                        end
                        CMD_RET: begin
                            pop  = 1'b1;
                            pc_d = stk_top[PC_W-1:0];
                        end
                        CMD_RETI: begin
                            pop  = 1'b1;
                            pc_d = stk_top[PC_W-1:0];
                            c_d  = stk_top[PC_W+1];
                            z_d  = stk_top[PC_W];
                            ie_d = 1'b1;
                        end
                        CMD_INTCTL: begin
                            pc_d = pc_inc;
                            ie_d = cond_sel[0];
                        end
                    endcase
                    if (irq_req && ie_d) state_d = ST_ENTER;
                end
            end
            ST_ENTER: begin
                push      = 1'b1;
                push_data = {c_q, z_q, pc_q};
                pc_d      = PC_W'(VEC_ADDR);
                ie_d      = 1'b0;
                state_d   = ST_RUN;
            end
        endcase
        err_d = err_q | (push && stk_full) | (pop && stk_empty);
    end

    // Outputs
    always_comb begin
        pc_o      = pc_q;
        busy_o    = (state_q == ST_ENTER);
        carry_o   = c_q;
        zero_o    = z_q;
        ie_o      = ie_q;
        stk_err_o = err_q;
    end

endmodule

// File: rtl/pfc_chk.sv
module pfc_chk
    import pfc_pkg::*;
#(
    parameter int PC_W     = 10,
    parameter int VEC_ADDR = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_done,
    input logic [2:0]      cmd,
    input logic [PC_W-1:0] target,
    input logic            irq_req,
    input logic [PC_W-1:0] pc_o,
    input logic            busy_o,
    input logic            carry_o,
    input logic            zero_o,
    input logic            ie_o,
    input logic            stk_err_o
);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !busy_o && cmd == CMD_NEXT) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

    a_r3_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !busy_o && cmd != CMD_ALU && cmd != CMD_RETI) |=> ($stable(carry_o) && $stable(zero_o)));

    a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !busy_o && cmd == CMD_JUMP) |=> (pc_o == $past(target)));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err_o |=> stk_err_o);

    a_r9_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o && pc_o == PC_W'(VEC_ADDR) && !ie_o));

    a_r9_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(irq_req) && $past(instr_done)));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_done && !busy_o) |=> ($stable(pc_o) && $stable(carry_o) && $stable(zero_o) && !busy_o));

endmodule

bind pfc_top pfc_chk #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) chk_i (.*);

// File: tb/pfc_top_tb.sv
`timescale 1ns/1ps
module pfc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_done = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [1:0] cond_sel = 2'd0;
    logic [9:0] target = '0;
    logic       alu_carry = 1'b0, alu_zero = 1'b0, irq_req = 1'b0;
    logic [9:0] pc_o;
    logic       busy_o, carry_o, zero_o, ie_o, stk_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pfc_top dut_i (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .cmd(cmd),
        .cond_sel(cond_sel), .target(target), .alu_carry(alu_carry),
        .alu_zero(alu_zero), .irq_req(irq_req), .pc_o(pc_o), .busy_o(busy_o),
        .carry_o(carry_o), .zero_o(zero_o), .ie_o(ie_o), .stk_err_o(stk_err_o)
    );

    // cmd, cond, target, alu_c, alu_z | expected pc, carry, zero
    localparam logic [28:0] VECS [14] = '{
        {3'd0, 2'b00, 10'h000, 1'b0, 1'b0, 10'h001, 1'b0, 1'b0},
        {3'd1, 2'b00, 10'h000, 1'b1, 1'b0, 10'h002, 1'b1, 1'b0},
        {3'd3, 2'b10, 10'h100, 1'b0, 1'b0, 10'h100, 1'b1, 1'b0},
        {3'd3, 2'b00, 10'h200, 1'b0, 1'b0, 10'h101, 1'b1, 1'b0},
        {3'd3, 2'b01, 10'h050, 1'b0, 1'b0, 10'h050, 1'b1, 1'b0},
        {3'd1, 2'b00, 10'h000, 1'b0, 1'b1, 10'h051, 1'b0, 1'b1},
        {3'd3, 2'b11, 10'h3F0, 1'b0, 1'b0, 10'h3F0, 1'b0, 1'b1},
        {3'd3, 2'b10, 10'h000, 1'b0, 1'b0, 10'h3F1, 1'b0, 1'b1},
        {3'd2, 2'b00, 10'h3FF, 1'b0, 1'b0, 10'h3FF, 1'b0, 1'b1},
        {3'd0, 2'b00, 10'h000, 1'b0, 1'b0, 10'h000, 1'b0, 1'b1},
        {3'd3, 2'b00, 10'h123, 1'b0, 1'b0, 10'h123, 1'b0, 1'b1},
        {3'd2, 2'b00, 10'h000, 1'b1, 1'b0, 10'h000, 1'b0, 1'b1},
        {3'd1, 2'b00, 10'h000, 1'b1, 1'b1, 10'h001, 1'b1, 1'b1},
        {3'd3, 2'b01, 10'h2AA, 1'b0, 1'b0, 10'h002, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs, let one edge pass, return at the following falling edge
    task automatic cyc(input logic [2:0] c, input logic [1:0] cs, input logic [9:0] t,
                       input logic ac, input logic az, input logic dn, input logic irq);
        cmd = c; cond_sel = cs; target = t; alu_carry = ac; alu_zero = az;
        instr_done = dn; irq_req = irq;
        @(posedge clk);
        @(negedge clk);
        instr_done = 1'b0;
        irq_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        instr_done = 1'b0;
        irq_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pc", pc_o, 0);
        chk("R1 flags", {busy_o, carry_o, zero_o, ie_o, stk_err_o}, 0);

        // R2 R3 R4 R5 vector walk
        for (int i = 0; i < 14; i++) begin
            logic [28:0] v;
            v = VECS[i];
            cyc(v[28:26], v[25:24], v[23:14], v[13], v[12], 1'b1, 1'b0);
            chk("R2/R4/R5 vector pc", pc_o, v[11:2]);
            chk("R3 vector flags", {carry_o, zero_o}, v[1:0]);
        end

        // R12 commands ignored while instr_done is low
        cyc(3'd2, 2'b00, 10'h3AB, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(3'd1, 2'b00, 10'h3AB, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R12 idle pc", pc_o, 10'h002);
        chk("R12 idle flags", {carry_o, zero_o, busy_o}, 3'b110);

        // R11 interrupt enable control
        cyc(3'd7, 2'b01, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R11 enable", {ie_o, pc_o}, {1'b1, 10'h003});
        cyc(3'd7, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R11 disable with irq ignored", {ie_o, busy_o, pc_o}, {2'b00, 10'h004});

        // R6 R7 stack overflow
        do_reset();
        cyc(3'd2, 2'b00, 10'h010, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(3'd4, 2'b00, 10'h100, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 call target", pc_o, 10'h100);
        cyc(3'd4, 2'b00, 10'h200, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(3'd4, 2'b00, 10'h300, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(3'd4, 2'b00, 10'h040, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 no error at four", stk_err_o, 0);
        cyc(3'd4, 2'b00, 10'h080, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 overflow flagged", stk_err_o, 1);
        cyc(3'd5, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 pop 1", pc_o, 10'h041);
        cyc(3'd5, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 pop 2", pc_o, 10'h301);
        cyc(3'd5, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 pop 3", pc_o, 10'h201);
        cyc(3'd5, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 pop 4 oldest lost", pc_o, 10'h101);
        cyc(3'd5, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 empty pop zero", pc_o, 10'h000);

        // R8 underflow from a fresh reset, sticky afterwards
        do_reset();
        cyc(3'd2, 2'b00, 10'h155, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(3'd5, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 underflow", {stk_err_o, pc_o}, {1'b1, 10'h000});
        cyc(3'd4, 2'b00, 10'h020, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 sticky", stk_err_o, 1);

        // R9 R10 interrupt entry and return
        do_reset();
        cyc(3'd1, 2'b00, 10'h000, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(3'd7, 2'b01, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(3'd0, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 entry cycle", {busy_o, pc_o}, {1'b1, 10'h003});
        // R12 command during busy is ignored
        cyc(3'd2, 2'b00, 10'h222, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 vector", {busy_o, ie_o, pc_o}, {2'b00, 10'h008});
        cyc(3'd1, 2'b00, 10'h000, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R9 masked in handler", {busy_o, pc_o, carry_o, zero_o}, {1'b0, 10'h009, 2'b01});
        cyc(3'd6, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 return", {ie_o, pc_o, carry_o, zero_o}, {1'b1, 10'h003, 2'b10});

        // R9 return address after a jump
        cyc(3'd2, 2'b00, 10'h150, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 jump entry", {busy_o, pc_o}, {1'b1, 10'h150});
        cyc(3'd0, 2'b00, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 jump vector", pc_o, 10'h008);
        cyc(3'd6, 2'b00, 10'h000, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 jump return", {ie_o, pc_o}, {1'b1, 10'h150});

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule